// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns an oscillator-enable strobe into a one-second tick for a calendar counter. The strobe arrives once per oscillator cycle at a nominal 32768 per second. The division has two stages: a fine stage that nominally counts 256 strobes, then a coarse stage that counts 128 fine periods. A digital trim adjusts the tick rate without touching the oscillator. Over a repeating 64-minute correction cycle, the first second of some minutes is made shorter or longer by changing the length of a single fine period.

A 5-bit magnitude N and a direction bit set the trim. The magnitude selects how many minutes, counted from the start of the cycle, carry an adjusted second. The direction bit selects whether those seconds run fast or slow. Both values are captured when a correction cycle begins, and they hold for the whole cycle. A stop input freezes all counting, and when stop is released the sub-second prescaler starts again from zero.

Every count is a parameter. With the default parameters the block gives 32768 strobes per second, 60 seconds per minute and 64 minutes per cycle.

Top module: `trimmed_second_divider`

## Requirements
- R1: With no adjustment in force, a second lasts exactly FINE_DIV*COARSE_DIV accepted strobes (32768 by default). An accepted strobe is a cycle with `osc_en`=1, `stop`=0 and `rst_n`=1.
- R2: `sec_tick` is high for exactly one clock cycle: the cycle after the clock edge that accepts the last strobe of a second. It never follows a cycle without an accepted strobe.
- R3: When `cal_pos`=1, an adjusted second is shorter by FINE_DIV/2 strobes (128 by default), so the clock runs faster.
- R4: When `cal_pos`=0, an adjusted second is longer by FINE_DIV strobes (256 by default), so the clock runs slower.
- R5: The adjusted seconds are second 0 of each minute m with m < min(2*N, MIN_PER_CYCLE-2). Minutes are numbered from 0 at the start of the correction cycle.
- R6: A magnitude of 0 leaves every second at the nominal length, whatever `cal_pos` is.
- R7: The block captures `cal_mag` and `cal_pos` during reset and at the edge that ends the last second of a cycle. Changes at any other time have no effect until the next capture.
- R8: While `stop`=1, no strobe is accepted and `sec_tick` stays low. The second and minute positions hold. After release, the current second starts over at its full length (prescaler restarted from zero).
- R9: During synchronous reset (`rst_n`=0), `sec_tick` is low. After reset the block is at second 0 of minute 0 of a new cycle with an empty prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One strobe per oscillator cycle |
| stop | input | 1 | Freezes counting; on release the prescaler restarts from zero |
| cal_mag | input | 5 | Trim magnitude N, 0 to 31 |
| cal_pos | input | 1 | Trim direction: 1 = faster, 0 = slower |
| sec_tick | output | 1 | One-cycle pulse per trimmed second |

## Verification
The hardest situation to reach is a stop that lands inside an adjusted second near a cycle boundary, while the trim inputs change just before the capture edge. At the default sizes a correction cycle spans more than a hundred million strobes, so the bench shrinks every divider parameter until a whole cycle takes a few hundred strobes. It then runs many cycles under random strobe density, random trim changes and random stop bursts, after directed runs for each direction and for the capped magnitude.

// File: rtl/trim_div_pkg.sv
// Shared types for the trimmed one-second prescaler.
package trim_div_pkg;
    // Width of the trim magnitude field.
    localparam int CAL_W = 5;

    // How the current second is adjusted.
    typedef enum logic [1:0] {
        TRIM_NONE  = 2'd0,
        TRIM_SHORT = 2'd1,
        TRIM_LONG  = 2'd2
    } trim_e;
endpackage

// File: rtl/trim_prescaler.sv
// Two-stage sub-second divider. The fine stage counts FINE_DIV strobes and the
// coarse stage counts COARSE_DIV fine periods. The trim lengthens or shortens
// only the first fine period of a second.
// Assumes: FINE_DIV is even and at least 2, COARSE_DIV is at least 2, and
//          trim stays stable for the whole second.
module trim_prescaler
    import trim_div_pkg::*;
#(
    parameter int FINE_DIV   = 256,
    parameter int COARSE_DIV = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  osc_en,
    input  logic  halt,
    input  trim_e trim,
    output logic  sec_done
);
    localparam int FW = $clog2(2 * FINE_DIV);
    localparam int CW = $clog2(COARSE_DIV);
    localparam logic [FW-1:0] TOP_NORM  = FW'(FINE_DIV - 1);
    localparam logic [FW-1:0] TOP_SHORT = FW'(FINE_DIV / 2 - 1);
    localparam logic [FW-1:0] TOP_LONG  = FW'(2 * FINE_DIV - 1);
    localparam logic [CW-1:0] COARSE_LAST = CW'(COARSE_DIV - 1);

    logic [FW-1:0] fine_q;
    logic [FW-1:0] fine_top;
    logic [CW-1:0] coarse_q;
    logic          fine_end;

    // Pick the terminal count of the fine stage for the current fine period.
    always_comb begin
        fine_top = TOP_NORM;
        if (coarse_q == '0) begin
            if (trim == TRIM_SHORT)
                fine_top = TOP_SHORT;
            else if (trim == TRIM_LONG)
                fine_top = TOP_LONG;
        end
    end

    assign fine_end = osc_en && !halt && (fine_q == fine_top);
    assign sec_done = fine_end && (coarse_q == COARSE_LAST);

    // Advance both stages on each accepted strobe; a halt clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (osc_en) begin
            if (fine_q == fine_top) begin
                fine_q   <= '0;
                coarse_q <= (coarse_q == COARSE_LAST) ? '0 : coarse_q + 1'b1;
            end else begin
                fine_q <= fine_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cycle_tracker.sv
// Tracks the second within the minute and the minute within the correction
// cycle, and flags the edge that closes a cycle.
// Assumes: sec_done is a single-cycle strobe and both counts are at least 2.
module cycle_tracker #(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    localparam int SW = $clog2(SEC_PER_MIN),
    localparam int MW = $clog2(MIN_PER_CYCLE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_done,
    output logic [SW-1:0] sec_idx,
    output logic [MW-1:0] min_idx,
    output logic          cycle_wrap
);
    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);
    localparam logic [MW-1:0] MIN_LAST = MW'(MIN_PER_CYCLE - 1);

    logic sec_last;
    logic min_last;

    assign sec_last   = (sec_idx == SEC_LAST);
    assign min_last   = (min_idx == MIN_LAST);
    assign cycle_wrap = sec_done && sec_last && min_last;

    // Step the second and minute positions once per finished second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_idx <= '0;
            min_idx <= '0;
        end else if (sec_done) begin
            if (sec_last) begin
                sec_idx <= '0;
                min_idx <= min_last ? '0 : min_idx + 1'b1;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trim_scheduler.sv
// Captures the trim setting at each cycle start and decides whether the
// current second is adjusted: second 0 of the first 2*N minutes, capped at
// MIN_PER_CYCLE-2 minutes.
// Assumes: cycle_wrap is high only on the edge that closes a cycle.
module trim_scheduler
    import trim_div_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    localparam int SW = $clog2(SEC_PER_MIN),
    localparam int MW = $clog2(MIN_PER_CYCLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             cycle_wrap,
    input  logic [SW-1:0]    sec_idx,
    input  logic [MW-1:0]    min_idx,
    output trim_e            trim,
    output logic [CAL_W-1:0] lat_mag,
    output logic             lat_pos
);
    localparam logic [31:0] ADJ_LIMIT = 32'(MIN_PER_CYCLE - 2);

    logic [31:0] span;
    logic        in_window;

    // Hold the trim setting for a full cycle; reload it at reset and at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n || cycle_wrap) begin
            lat_mag <= cal_mag;
            lat_pos <= cal_pos;
        end
    end

    // Work out the number of adjusted minutes and the trim for this second.
    always_comb begin
        span = 32'(lat_mag) << 1;
        if (span > ADJ_LIMIT)
            span = ADJ_LIMIT;
        in_window = (sec_idx == '0) && (32'(min_idx) < span);
        if (!in_window)
            trim = TRIM_NONE;
        else if (lat_pos)
            trim = TRIM_SHORT;
        else
            trim = TRIM_LONG;
    end
endmodule

// File: rtl/trimmed_second_divider.sv
// Top of the trimmed one-second prescaler. It divides oscillator strobes down
// to a registered one-cycle second tick and applies the scheduled trim.
// Assumes: osc_en is at most one strobe per clock, synchronous to clk.
module trimmed_second_divider
    import trim_div_pkg::*;
#(
    parameter int FINE_DIV      = 256,
    parameter int COARSE_DIV    = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             stop,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output logic             sec_tick
);
    localparam int SW = $clog2(SEC_PER_MIN);
    localparam int MW = $clog2(MIN_PER_CYCLE);

    trim_e            trim;
    logic             sec_done;
    logic             cycle_wrap;
    logic [SW-1:0]    sec_idx;
    logic [MW-1:0]    min_idx;
    logic [CAL_W-1:0] lat_mag;
    logic             lat_pos;

    trim_prescaler #(
        .FINE_DIV   (FINE_DIV),
        .COARSE_DIV (COARSE_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .halt     (stop),
        .trim     (trim),
        .sec_done (sec_done)
    );

    cycle_tracker #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_done   (sec_done),
        .sec_idx    (sec_idx),
        .min_idx    (min_idx),
        .cycle_wrap (cycle_wrap)
    );

    trim_scheduler #(
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_CYCLE (MIN_PER_CYCLE)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_mag    (cal_mag),
        .cal_pos    (cal_pos),
        .cycle_wrap (cycle_wrap),
        .sec_idx    (sec_idx),
        .min_idx    (min_idx),
        .trim       (trim),
        .lat_mag    (lat_mag),
        .lat_pos    (lat_pos)
    );

    // Register the end-of-second strobe as the outgoing tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_tick <= 1'b0;
        else
            sec_tick <= sec_done;
    end
endmodule

// File: rtl/trimmed_second_divider_chk.sv
// Property checker for the trimmed one-second prescaler, bound to the top.
// Assumes: it sees the top's ports plus its cycle_wrap and captured trim.
module trimmed_second_divider_chk
    import trim_div_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             stop,
    input logic [CAL_W-1:0] cal_mag,
    input logic             cal_pos,
    input logic             sec_tick,
    input logic             cycle_wrap,
    input logic [CAL_W-1:0] lat_mag,
    input logic             lat_pos
);
    // R2: the tick is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R2: no tick without an accepted strobe on the previous edge
    a_r2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !sec_tick);

    // R2: closing a cycle always produces a tick
    a_r2_wrap_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_wrap |=> sec_tick);

    // R8: stop silences the tick
    a_r8_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_tick);

    // R7: the captured trim holds between cycle boundaries
    a_r7_trim_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_wrap |=> $stable({lat_mag, lat_pos}));

    // R7: the captured trim takes the inputs present at the cycle boundary
    a_r7_trim_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_wrap |=> ({lat_mag, lat_pos} == $past({cal_mag, cal_pos})));
endmodule

bind trimmed_second_divider trimmed_second_divider_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .stop       (stop),
    .cal_mag    (cal_mag),
    .cal_pos    (cal_pos),
    .sec_tick   (sec_tick),
    .cycle_wrap (cycle_wrap),
    .lat_mag    (lat_mag),
    .lat_pos    (lat_pos)
);

// File: tb/trimmed_second_divider_test.sv
// Bench for the trimmed one-second prescaler, using shrunken dividers.
module trimmed_second_divider_test;
    localparam int FINE   = 8;
    localparam int COARSE = 4;
    localparam int SPM    = 3;
    localparam int MPC    = 8;
    localparam int BASE   = FINE * COARSE;
    localparam int LIMIT  = MPC - 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       stop = 1'b0;
    logic [4:0] cal_mag = 5'd0;
    logic       cal_pos = 1'b0;
    logic       sec_tick;

    int    checks = 0;
    int    fails = 0;
    int    cnt = 0;
    int    m_sec = 0;
    int    m_min = 0;
    int    m_mag = 0;
    logic  m_pos = 1'b0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R9";

    always #2 clk = ~clk;

    trimmed_second_divider #(
        .FINE_DIV      (FINE),
        .COARSE_DIV    (COARSE),
        .SEC_PER_MIN   (SPM),
        .MIN_PER_CYCLE (MPC)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .stop     (stop),
        .cal_mag  (cal_mag),
        .cal_pos  (cal_pos),
        .sec_tick (sec_tick)
    );

    // Expected second length from the requirements (R1, R3, R4, R5, R6).
    function automatic int exp_len(int s, int m, int mag, logic pos);
        int span;
        span = 2 * mag;
        if (span > LIMIT) span = LIMIT;
        if (s == 0 && m < span)
            return pos ? BASE - FINE / 2 : BASE + FINE;
        return BASE;
    endfunction

    task automatic check(bit ok, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, expv);
        end
    endtask

    // Compare the tick with the reference model after each edge.
    task automatic observe();
        int e;
        string kind;
        if (!rst_n) begin
            cnt = 0; m_sec = 0; m_min = 0;
            m_mag = int'(cal_mag); m_pos = cal_pos;
            check(sec_tick == 1'b0, "R9 tick during reset", int'(sec_tick), 0);
            return;
        end
        if (stop) begin
            cnt = 0;
            check(sec_tick == 1'b0, {phase, " R8 tick while stopped"}, int'(sec_tick), 0);
            return;
        end
        if (osc_en) cnt++;
        e = exp_len(m_sec, m_min, m_mag, m_pos);
        if (sec_tick || cnt == e) begin
            if (e != BASE) kind = m_pos ? "R3 R5 adjusted fast" : "R4 R5 adjusted slow";
            else if (m_mag == 0) kind = "R6 R1 zero trim";
            else kind = "R1 R5 plain second";
            check(sec_tick && cnt == e, {phase, " R2 ", kind, " length"},
                  sec_tick ? cnt : -1, e);
            cnt = 0;
            m_sec++;
            if (m_sec == SPM) begin
                m_sec = 0;
                m_min++;
                if (m_min == MPC) begin
                    m_min = 0;
                    m_mag = int'(cal_mag);
                    m_pos = cal_pos;
                end
            end
        end
    endtask

    task automatic step(logic en, logic st, logic [4:0] mg, logic ps);
        @(negedge clk);
        observe();
        osc_en = en; stop = st; cal_mag = mg; cal_pos = ps;
    endtask

    task automatic run(int n, logic [4:0] mg, logic ps);
        repeat (n) step(1'b1, 1'b0, mg, ps);
    endtask

    task automatic do_reset(logic [4:0] mg, logic ps);
        @(negedge clk);
        observe();
        rst_n = 1'b0; osc_en = 1'b0; stop = 1'b0; cal_mag = mg; cal_pos = ps;
        repeat (3) step(1'b0, 1'b0, mg, ps);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog expired: got %0d cycles expected fewer than 190000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        int stop_left;
        int dens;
        logic [4:0] mg;
        logic ps;
        void'($urandom(32'd4711));

        phase = "R9";
        do_reset(5'd0, 1'b1);
        phase = "R6";
        run(1700, 5'd0, 1'b1);
        // R7: the change to 1 takes effect only at the next cycle boundary.
        phase = "R3";
        run(1700, 5'd1, 1'b1);
        phase = "R4";
        run(1700, 5'd1, 1'b0);
        phase = "R4";
        run(1700, 5'd2, 1'b0);
        // R5: a magnitude of 31 is capped at MPC-2 adjusted minutes.
        phase = "R5";
        run(1700, 5'd31, 1'b1);
        // R8: stop in the middle of an adjusted second, then restart.
        phase = "R8";
        do_reset(5'd3, 1'b0);
        run(45, 5'd3, 1'b0);
        repeat (20) step(1'b1, 1'b1, 5'd3, 1'b0);
        run(1700, 5'd3, 1'b0);

        // R7 and R8 under random strobes, trim changes and stop bursts.
        phase = "R7";
        stop_left = 0;
        mg = 5'd5; ps = 1'b1; dens = 60;
        for (int i = 0; i < 60000; i++) begin
            if (i % 5000 == 0) dens = $urandom_range(30, 100);
            if (i == 30000) begin
                do_reset(5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
                mg = cal_mag; ps = cal_pos;
            end
            if ($urandom_range(0, 49) == 0) begin
                mg = 5'($urandom_range(0, 31));
                ps = 1'($urandom_range(0, 1));
            end
            if (stop_left > 0) stop_left--;
            else if ($urandom_range(0, 399) == 0) stop_left = $urandom_range(1, 30);
            step(1'($urandom_range(0, 99) < dens), stop_left > 0, mg, ps);
        end
        step(1'b0, 1'b0, mg, ps);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule